// File: doc/BRIEF.md
# I2C Register Access Slave

This block is an I2C target that gives a bus master read and write access to a small register map. Register addresses and data words are both 16 bits wide. The block has a fixed 7-bit device address. A write sends the register pointer as two bytes and then one or more data words. A read sets the pointer the same way, then uses a repeated start with the read bit set and clocks data words back out. Every word crosses the bus high byte first.

Register 0 is the configuration register. Its bit 0 enables auto-increment, and it comes out of reset set. When auto-increment is on, consecutive words in one transaction go to consecutive addresses. When it is off, every word in the transaction goes to the same address.

The block oversamples SCL and SDA with its own clock. It finds start and stop conditions as SDA edges while SCL is high. It drives SDA only through an open-drain pull-down. The `alt_iface` input parks the block when the interface-select strap chooses the other control port.

Top module: `i2cr_slave`

## Requirements
- R1: After reset, `sda_pull` is 0, register 0 reads 0x0001 (auto-increment enabled), and all other registers read 0x0000.
- R2: The slave acknowledges the first byte after a start only when its upper 7 bits equal the device address (default 0x1A; bit 0 is the direction, 0 = write, 1 = read). With any other address, the slave gives no acknowledge for that byte or any later byte, and no register changes.
- R3: After a matching address byte with bit 0 = 0, the slave acknowledges every received byte, and every register write is accompanied by an acknowledge.
- R4: In a write, the first two bytes load the pointer (high byte, then low byte). Each data word follows as a high byte then a low byte. A register changes only when the low byte arrives, so a transaction that stops after only the high byte leaves the register unchanged.
- R5: After a repeated start with an address byte whose bit 0 = 1, the slave returns the word at the current pointer, high byte first. It keeps returning words while the master acknowledges.
- R6: With register 0 bit 0 = 1, each completed word (write or read) advances the pointer by one, so a burst covers successive addresses.
- R7: With register 0 bit 0 = 0, the pointer does not move. Burst writes all land on one address (the last word wins), and burst reads repeat the same word.
- R8: The map holds addresses 0 to DEPTH-1 (default 8). Writes to higher addresses are ignored, and reads from them return 0x0000.
- R9: While `alt_iface` is 1, the slave never pulls SDA and ignores all bus traffic.
- R10: SDA is only pulled low or released, and the pull is applied only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_iface | input | 1 | 1 = other control port selected, slave idle |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
A table of single-word write-then-read vectors uses in-range and out-of-range addresses, including the top of the 16-bit space. These vectors separate a correctly decoded pointer and byte order from address aliasing or swapped bytes. Two-word bursts, run once with auto-increment on and once with it off, show whether the pointer steps or stays. The patterns are a foreign device address, a write stopped after its high data byte, and traffic sent while the slave is parked. Together they show that nothing reaches the map without a full, addressed, enabled word.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam logic [DATA_W-1:0] CFG_INIT = 16'h0001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TACK
    } xfer_st_t;

    typedef enum logic [1:0] {
        BY_PTR_HI,
        BY_PTR_LO,
        BY_DAT_HI,
        BY_DAT_LO
    } wbyte_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } line_ev_t;

    function automatic logic [ADDR_W-1:0] step_ptr(input logic [ADDR_W-1:0] p, input logic inc);
        return inc ? p + ADDR_W'(1) : p;
    endfunction

endpackage

// File: rtl/i2cr_line_mon.sv
module i2cr_line_mon
    import i2cr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_s, sda_s;
    logic scl_q, sda_q, scl_n, sda_n;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_s <= '1;
                    sda_s <= '1;
                end else begin
                    scl_s <= scl_i;
                    sda_s <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_s <= '1;
                    sda_s <= '1;
                end else begin
                    scl_s <= {scl_s[SYNC_STAGES-2:0], scl_i};
                    sda_s <= {sda_s[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_n = scl_s[SYNC_STAGES-1];
    assign sda_n = sda_s[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_n;
            sda_q <= sda_n;
        end
    end

    always_comb begin
        ev.scl_rise = scl_n & ~scl_q;
        ev.scl_fall = ~scl_n & scl_q;
        ev.start    = scl_n & scl_q & sda_q & ~sda_n;
        ev.stop     = scl_n & scl_q & ~sda_q & sda_n;
        ev.sda      = sda_n;
    end
endmodule

// File: rtl/i2cr_regfile.sv
module i2cr_regfile
    import i2cr_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata,
    output logic              auto_inc
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [DATA_W-1:0] regs [DEPTH];
    logic w_in, r_in;

    assign w_in = (waddr <= LAST);
    assign r_in = (raddr <= LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                regs[i] <= (i == 0) ? CFG_INIT : '0;
        end else if (we && w_in) begin
            regs[waddr[IW-1:0]] <= wdata;
        end
    end

    assign rdata    = r_in ? regs[raddr[IW-1:0]] : '0;
    assign auto_inc = regs[0][0];
endmodule

// File: rtl/i2cr_xfer_fsm.sv
module i2cr_xfer_fsm
    import i2cr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h1A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  line_ev_t          ev,
    input  logic              auto_inc,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata,
    output logic              sda_pull
);
    xfer_st_t          st;
    wbyte_t            bidx;
    logic [3:0]        cnt;
    logic [7:0]        sh;
    logic [7:0]        hold;
    logic [7:0]        word_lo;
    logic              rw, tx_lo, mack, pull;
    logic [ADDR_W-1:0] ptr, ptr_nx;
    logic              byte_done;

    assign ptr_nx    = step_ptr(ptr, auto_inc);
    assign byte_done = ev.scl_fall && (cnt == 4'd8);
    assign rd_addr   = (st == ST_TACK && tx_lo) ? ptr_nx : ptr;
    assign we        = enable && !ev.start && !ev.stop && st == ST_RX
                       && byte_done && bidx == BY_DAT_LO;
    assign waddr     = ptr;
    assign wdata     = {hold, sh};
    assign sda_pull  = pull;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            bidx    <= BY_PTR_HI;
            cnt     <= '0;
            sh      <= '0;
            hold    <= '0;
            word_lo <= '0;
            rw      <= 1'b0;
            tx_lo   <= 1'b0;
            mack    <= 1'b0;
            pull    <= 1'b0;
            ptr     <= '0;
        end else if (!enable) begin
            st   <= ST_IDLE;
            pull <= 1'b0;
        end else if (ev.start) begin
            st   <= ST_DEV;
            cnt  <= '0;
            bidx <= BY_PTR_HI;
            pull <= 1'b0;
        end else if (ev.stop) begin
            st   <= ST_IDLE;
            pull <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: ;
                ST_DEV, ST_RX: begin
                    if (ev.scl_rise && cnt < 4'd8) begin
                        sh  <= {sh[6:0], ev.sda};
                        cnt <= cnt + 4'd1;
                    end else if (byte_done) begin
                        if (st == ST_DEV) begin
                            if (sh[7:1] == DEV_ADDR) begin
                                pull <= 1'b1;
                                rw   <= sh[0];
                                st   <= ST_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            pull <= 1'b1;
                            rw   <= 1'b0;
                            st   <= ST_ACK;
                            unique case (bidx)
                                BY_PTR_HI: begin
                                    hold <= sh;
                                    bidx <= BY_PTR_LO;
                                end
                                BY_PTR_LO: begin
                                    ptr  <= {hold, sh};
                                    bidx <= BY_DAT_HI;
                                end
                                BY_DAT_HI: begin
                                    hold <= sh;
                                    bidx <= BY_DAT_LO;
                                end
                                BY_DAT_LO: begin
                                    ptr  <= ptr_nx;
                                    bidx <= BY_DAT_HI;
                                end
                            endcase
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            sh      <= rd_data[15:8];
                            word_lo <= rd_data[7:0];
                            pull    <= ~rd_data[15];
                            tx_lo   <= 1'b0;
                            st      <= ST_TX;
                        end else begin
                            pull <= 1'b0;
                            st   <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (cnt == 4'd7) begin
                            pull <= 1'b0;
                            cnt  <= '0;
                            st   <= ST_TACK;
                        end else begin
                            sh   <= {sh[6:0], 1'b0};
                            pull <= ~sh[6];
                            cnt  <= cnt + 4'd1;
                        end
                    end
                end
                ST_TACK: begin
                    if (ev.scl_rise) begin
                        mack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (tx_lo)
                            ptr <= ptr_nx;
                        if (mack) begin
                            cnt <= '0;
                            st  <= ST_TX;
                            if (tx_lo) begin
                                sh      <= rd_data[15:8];
                                word_lo <= rd_data[7:0];
                                pull    <= ~rd_data[15];
                                tx_lo   <= 1'b0;
                            end else begin
                                sh    <= word_lo;
                                pull  <= ~word_lo[7];
                                tx_lo <= 1'b1;
                            end
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2cr_slave.sv
module i2cr_slave
    import i2cr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h1A,
    parameter int         DEPTH       = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic alt_iface,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull
);
    line_ev_t          ev;
    logic              auto_inc;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    i2cr_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2cr_xfer_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .enable   (~alt_iface),
        .ev       (ev),
        .auto_inc (auto_inc),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .we       (wr_en),
        .waddr    (wr_addr),
        .wdata    (wr_data),
        .sda_pull (sda_pull)
    );

    i2cr_regfile #(.DEPTH(DEPTH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_en),
        .waddr    (wr_addr),
        .wdata    (wr_data),
        .raddr    (rd_addr),
        .rdata    (rd_data),
        .auto_inc (auto_inc)
    );
endmodule

// File: rtl/i2cr_slave_chk.sv
module i2cr_slave_chk (
    input logic clk,
    input logic rst,
    input logic alt_iface,
    input logic scl_i,
    input logic sda_pull,
    input logic wr_en
);
    // R1
    reset_release_chk: assert property (@(posedge clk) rst |=> !sda_pull);

    // R3
    write_acked_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> sda_pull);

    // R9
    parked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (alt_iface && $past(alt_iface)) |-> !sda_pull);

    // R10
    pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_i);

    // R9
    parked_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        alt_iface |-> !wr_en);
endmodule

bind i2cr_slave i2cr_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .alt_iface (alt_iface),
    .scl_i     (scl_i),
    .sda_pull  (sda_pull),
    .wr_en     (wr_en)
);

// File: tb/tb_i2cr_slave.sv
module tb_i2cr_slave;
    localparam int        T   = 8;
    localparam logic [6:0] DEV = 7'h1A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alt_iface = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic line_w;
    logic sda_pull;

    int n_chk = 0;
    int n_err = 0;
    int r10_bad = 0;
    int r9_bad = 0;
    logic pull_q = 1'b0;

    always #10 clk = ~clk;

    assign line_w = sda_m & ~sda_pull;

    i2cr_slave dut (
        .clk       (clk),
        .rst       (rst),
        .alt_iface (alt_iface),
        .scl_i     (scl),
        .sda_i     (line_w),
        .sda_pull  (sda_pull)
    );

    always @(posedge clk) begin
        pull_q <= sda_pull;
        if (!rst && sda_pull && !pull_q && scl) r10_bad++;
        if (!rst && alt_iface && sda_pull) r9_bad++;
    end

    // {addr, write data, expected readback}
    localparam logic [47:0] VEC [5] = '{
        {16'h0001, 16'hA5C3, 16'hA5C3},
        {16'h0007, 16'h0F0F, 16'h0F0F},
        {16'h0008, 16'h1234, 16'h0000},
        {16'hFFFF, 16'hBEEF, 16'h0000},
        {16'h0002, 16'h8001, 16'h8001}
    };

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; tick(T);
        scl = 1'b1;   tick(T);
        sda_m = 1'b0; tick(T);
        scl = 1'b0;   tick(T);
    endtask

    task automatic bstop();
        sda_m = 1'b0; tick(T);
        scl = 1'b1;   tick(T);
        sda_m = 1'b1; tick(T);
    endtask

    task automatic bit_xfer(input logic b, output logic s);
        sda_m = b;  tick(T);
        scl = 1'b1; tick(T);
        s = line_w; tick(T);
        scl = 1'b0; tick(T);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
        bit_xfer(1'b1, s);
        ack = ~s;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            bit_xfer(1'b1, s);
            d = {d[6:0], s};
        end
        bit_xfer(~give_ack, s);
    endtask

    task automatic reg_write(input logic [15:0] a, input int n,
                             input logic [15:0] w0, input logic [15:0] w1,
                             output int nacks);
        logic ack;
        logic [15:0] w;
        nacks = 0;
        bstart();
        wbyte({DEV, 1'b0}, ack); if (!ack) nacks++;
        wbyte(a[15:8], ack);     if (!ack) nacks++;
        wbyte(a[7:0], ack);      if (!ack) nacks++;
        for (int k = 0; k < n; k++) begin
            w = (k == 0) ? w0 : w1;
            wbyte(w[15:8], ack); if (!ack) nacks++;
            wbyte(w[7:0], ack);  if (!ack) nacks++;
        end
        bstop();
    endtask

    task automatic reg_read(input logic [15:0] a, input int n,
                            output logic [15:0] q0, output logic [15:0] q1);
        logic ack;
        logic [7:0] hb, lb;
        q0 = '0;
        q1 = '0;
        bstart();
        wbyte({DEV, 1'b0}, ack);
        wbyte(a[15:8], ack);
        wbyte(a[7:0], ack);
        bstart();
        wbyte({DEV, 1'b1}, ack);
        for (int k = 0; k < n; k++) begin
            rbyte(1'b1, hb);
            rbyte(k != n - 1, lb);
            if (k == 0) q0 = {hb, lb};
            else        q1 = {hb, lb};
        end
        bstop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [15:0] r0, r1;
        logic ack;
        int nk;

        tick(5);
        rst = 1'b0;
        tick(5);

        // R1 reset state
        chk("R1 pull", {15'd0, sda_pull}, 16'd0);
        reg_read(16'h0000, 1, r0, r1);
        chk("R1 cfg", r0, 16'h0001);
        reg_read(16'h0005, 1, r0, r1);
        chk("R1 reg5", r0, 16'h0000);

        // R4 R5 R8 vector table
        for (int i = 0; i < 5; i++) begin
            reg_write(VEC[i][47:32], 1, VEC[i][31:16], 16'h0, nk);
            reg_read(VEC[i][47:32], 1, r0, r1);
            chk((VEC[i][47:32] < 16'd8) ? "R4 R5 table" : "R8 table", r0, VEC[i][15:0]);
        end

        // R2 foreign device address
        bstart();
        wbyte({7'h2B, 1'b0}, ack);
        chk("R2 foreign nack", {15'd0, ack}, 16'd0);
        wbyte(8'h00, ack); wbyte(8'h01, ack);
        wbyte(8'h55, ack); wbyte(8'h66, ack);
        bstop();
        reg_read(16'h0001, 1, r0, r1);
        chk("R2 reg1 kept", r0, 16'hA5C3);

        // R3 R6 burst with auto-increment on
        reg_write(16'h0004, 2, 16'h4444, 16'h5555, nk);
        chk("R3 all acked", 16'(nk), 16'd0);
        reg_read(16'h0004, 2, r0, r1);
        chk("R6 word0", r0, 16'h4444);
        chk("R6 word1", r1, 16'h5555);

        // R4 write stopped after high byte
        bstart();
        wbyte({DEV, 1'b0}, ack);
        wbyte(8'h00, ack); wbyte(8'h03, ack);
        wbyte(8'h77, ack);
        bstop();
        reg_read(16'h0003, 1, r0, r1);
        chk("R4 partial", r0, 16'h0000);

        // R7 auto-increment off
        reg_write(16'h0000, 1, 16'h0000, 16'h0, nk);
        reg_write(16'h0003, 2, 16'h1111, 16'h2222, nk);
        reg_read(16'h0003, 1, r0, r1);
        chk("R7 last wins", r0, 16'h2222);
        reg_read(16'h0004, 1, r0, r1);
        chk("R7 next kept", r0, 16'h4444);
        reg_read(16'h0003, 2, r0, r1);
        chk("R7 rd0", r0, 16'h2222);
        chk("R7 rd1", r1, 16'h2222);
        reg_write(16'h0000, 1, 16'h0001, 16'h0, nk);

        // R9 parked
        alt_iface = 1'b1;
        tick(4);
        reg_write(16'h0006, 1, 16'hABCD, 16'h0, nk);
        chk("R9 no acks", 16'(nk), 16'd5);
        alt_iface = 1'b0;
        tick(4);
        reg_read(16'h0006, 1, r0, r1);
        chk("R9 reg6", r0, 16'h0000);
        chk("R9 never pulled", 16'(r9_bad), 16'd0);

        // R10 pull timing
        chk("R10 pull while scl high", 16'(r10_bad), 16'd0);

        // R1 reset after traffic
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(3);
        reg_read(16'h0001, 1, r0, r1);
        chk("R1 reg1 cleared", r0, 16'h0000);
        reg_read(16'h0000, 1, r0, r1);
        chk("R1 cfg restored", r0, 16'h0001);

        summary();
    end
endmodule